// File: doc/BRIEF.md
# SPI Serial Byte-Memory Slave Controller

This block is the slave side of a four-wire serial link in front of a byte-wide memory with a 15-bit address space. A host selects the block with an active-low select line and sends one command byte, then any address and data bytes that the command needs. Six commands are decoded: set the write latch, clear the write latch, read the status byte, write the status byte, read memory and write memory. Memory transfers take a 16-bit address whose top bit is ignored. They then stream any number of bytes through an internal address counter that wraps from the top of the space to zero. Each written byte reaches the array as soon as its eighth bit has arrived, so there is no page buffer and nothing to poll.

The block runs on a system clock several times faster than the serial clock. All four serial inputs pass through two-flop synchronizers, and serial clock edges are found in the system clock domain. Both clock polarities used by the common modes work (idle low, and idle high with a leading falling edge). Input bits are taken on rising edges and output bits change on falling edges. An active-low hold input freezes a frame part-way through. Write permission comes from a separate guard block that holds the write latch, two block-protect bits and a protect-enable bit for the status byte. The memory is a synchronous RAM model that decodes the low `MEM_AW` bits of the address.

Top module: `sermem_spi_slave`

## Requirements
- R1: A frame is the time the select line is low. Only its first byte is taken as a command, and the following byte values are recognised: 0x06 set write latch, 0x04 clear write latch, 0x05 read status, 0x01 write status, 0x03 read memory, 0x02 write memory. After a set or clear command, further bytes in the same frame have no effect.
- R2: The block takes bits on rising serial clock edges and changes the output on falling edges, MSB first. It works with the clock idling low or idling high.
- R3: Read and write memory are followed by a 16-bit address sent high byte first. Address bit 15 is ignored, so 0x8000|A refers to byte A.
- R4: Within a frame the address steps by one after each data byte, and 0x7FFF is followed by 0x0000.
- R5: A memory write stores each byte when its eighth bit arrives, for any number of bytes in a frame. A byte left incomplete when the select line rises is discarded.
- R6: Set write latch sets the latch and clear write latch clears it. A frame that carried a write memory or write status command clears it when the select line rises. Memory and status writes are refused while the latch is 0.
- R7: The status byte reads as {protect-enable, 0, 0, 0, block-protect[1:0], write latch, 0}, with protect-enable in bit 7 and the write latch in bit 1. Write status changes only bits 7, 3 and 2.
- R8: Block-protect value 1 refuses memory writes to 0x6000-0x7FFF, value 2 to 0x4000-0x7FFF, value 3 to every address, and value 0 refuses none.
- R9: While protect-enable is 1 and `wp_n` is 0, write status is refused.
- R10: `spi_miso_en` is 1 only while read data or status is being returned. It is 0 during command and address bytes, while the select line is high, and while hold is low.
- R11: While `spi_hold_n` is 0, serial clock and select activity is ignored and the frame state is kept. Releasing hold resumes the transfer at the bit where it stopped.
- R12: A first byte other than the six commands (including any byte with a non-zero upper nibble) makes the rest of the frame have no effect and return no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times the serial clock rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| spi_sck | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low select, delimits a frame |
| spi_hold_n | input | 1 | Active-low hold, pauses the frame |
| spi_mosi | input | 1 | Serial data from the host |
| wp_n | input | 1 | Active-low status write protect pin |
| spi_miso | output | 1 | Serial data to the host |
| spi_miso_en | output | 1 | Output enable for the tri-state driver of `spi_miso` |

## Verification
The hardest state to reach from the ports is a hold that lands in the middle of a byte. During such a hold the serial clock keeps toggling, and afterwards the frame has to continue from the exact bit where it stopped. The bench pulls hold low between two bits of the first data byte of a write burst and of a read burst. It clocks three spurious pulses with a different data level, checks that the output enable stays low, and releases hold. It then checks that the bytes written and read back match as if the pause never happened. The protection rules are swept over all four block-protect values at addresses on both sides of each boundary, each write preceded by its own latch-set frame.

// File: rtl/sermem_pkg.sv
package sermem_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W);

  typedef enum logic [7:0] {
    OP_SETWE = 8'h06,
    OP_CLRWE = 8'h04,
    OP_RDST  = 8'h05,
    OP_WRST  = 8'h01,
    OP_RDMEM = 8'h03,
    OP_WRMEM = 8'h02
  } op_e;

  typedef enum logic [2:0] {
    PH_CMD, PH_AHI, PH_ALO, PH_WDAT, PH_RDAT, PH_STRD, PH_STWR, PH_SKIP
  } phase_e;
endpackage

// File: rtl/sermem_sync.sv
module sermem_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/sermem_guard.sv
module sermem_guard (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_wel,
  input  logic       clr_wel,
  input  logic       st_we,
  input  logic [2:0] st_wdata,   // {protect-enable, block-protect[1:0]}
  input  logic       wp_n,
  input  logic [1:0] chk_top,    // two top bits of the target address
  output logic [7:0] status,
  output logic       mem_ok,
  output logic       st_ok
);
  logic       wel_q, wel_d;
  logic       wpen_q, wpen_d;
  logic [1:0] bp_q, bp_d;
  logic       blk;

  always_comb begin
    st_ok = wel_q & ~(wpen_q & ~wp_n);
    case (bp_q)
      2'd0:    blk = 1'b0;
      2'd1:    blk = &chk_top;
      2'd2:    blk = chk_top[1];
      default: blk = 1'b1;
    endcase
    mem_ok = wel_q & ~blk;
    status = {wpen_q, 3'b000, bp_q, wel_q, 1'b0};
  end

  always_comb begin
    wel_d  = wel_q;
    wpen_d = wpen_q;
    bp_d   = bp_q;
    if (set_wel) wel_d = 1'b1;
    if (clr_wel) wel_d = 1'b0;
    if (st_we && st_ok) begin
      wpen_d = st_wdata[2];
      bp_d   = st_wdata[1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel_q  <= 1'b0;
      wpen_q <= 1'b0;
      bp_q   <= 2'b00;
    end else begin
      wel_q  <= wel_d;
      wpen_q <= wpen_d;
      bp_q   <= bp_d;
    end
  end

  p_wel_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel_q) |-> $past(set_wel));
  p_wel_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wel && !set_wel) |=> !wel_q);
  p_st_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_we && wpen_q && !wp_n) |=> ($stable(bp_q) && $stable(wpen_q)));
endmodule

// File: rtl/sermem_ram.sv
module sermem_ram #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/sermem_spi_slave.sv
module sermem_spi_slave
  import sermem_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int MEM_AW = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_sck,
  input  logic spi_cs_n,
  input  logic spi_hold_n,
  input  logic spi_mosi,
  input  logic wp_n,
  output logic spi_miso,
  output logic spi_miso_en
);
  localparam int HI_W = ADDR_W - BYTE_W;

  logic sck_s, cs_s, hold_s, si_s, sck_q;
  logic sck_rise, sck_fall, frame_end, last_bit;

  phase_e              phase_q, phase_d;
  logic [CNT_W-1:0]    bitcnt_q, bitcnt_d;
  logic [BYTE_W-1:0]   shreg_q, shreg_d, obuf_q, obuf_d, byte_in, src;
  logic [ADDR_W-1:0]   addr_q, addr_d;
  logic                so_q, so_d, oe_q, oe_d, ld_q, ld_d;
  logic                wrf_q, wrf_d, isrd_q, isrd_d;

  logic                set_wel, clr_wel, st_we, ram_we, mem_ok, st_ok;
  logic [7:0]          status;
  logic [BYTE_W-1:0]   rdata;

  sermem_sync #(.W(4), .STAGES(2), .RST_VAL(4'b0110)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({spi_sck, spi_cs_n, spi_hold_n, spi_mosi}),
    .q({sck_s, cs_s, hold_s, si_s})
  );

  sermem_guard u_guard (
    .clk(clk), .rst_n(rst_n),
    .set_wel(set_wel), .clr_wel(clr_wel),
    .st_we(st_we), .st_wdata({byte_in[7], byte_in[3:2]}),
    .wp_n(wp_n), .chk_top(addr_q[ADDR_W-1 -: 2]),
    .status(status), .mem_ok(mem_ok), .st_ok(st_ok)
  );

  sermem_ram #(.AW(MEM_AW), .DW(BYTE_W)) u_ram (
    .clk(clk), .we(ram_we),
    .waddr(addr_q[MEM_AW-1:0]), .wdata(byte_in),
    .raddr(addr_q[MEM_AW-1:0]), .rdata(rdata)
  );

  // Edge detection; a low hold masks every serial event.
  assign sck_rise  = hold_s & ~cs_s & sck_s & ~sck_q;
  assign sck_fall  = hold_s & ~cs_s & ~sck_s & sck_q;
  assign frame_end = hold_s & cs_s;
  assign byte_in   = {shreg_q[BYTE_W-2:0], si_s};
  assign last_bit  = (bitcnt_q == CNT_W'(BYTE_W - 1));

  always_comb begin
    phase_d  = phase_q;
    bitcnt_d = bitcnt_q;
    shreg_d  = shreg_q;
    addr_d   = addr_q;
    obuf_d   = obuf_q;
    so_d     = so_q;
    oe_d     = oe_q;
    ld_d     = ld_q;
    wrf_d    = wrf_q;
    isrd_d   = isrd_q;
    set_wel  = 1'b0;
    clr_wel  = 1'b0;
    st_we    = 1'b0;
    ram_we   = 1'b0;
    src      = (phase_q == PH_STRD) ? status : rdata;
    if (frame_end) begin
      phase_d  = PH_CMD;
      bitcnt_d = '0;
      oe_d     = 1'b0;
      ld_d     = 1'b0;
      wrf_d    = 1'b0;
      clr_wel  = wrf_q;
    end else begin
      if (sck_rise) begin
        shreg_d  = byte_in;
        bitcnt_d = bitcnt_q + 1'b1;
        if (last_bit) begin
          case (phase_q)
            PH_CMD: begin
              isrd_d = (byte_in == OP_RDMEM);
              case (byte_in)
                OP_SETWE: begin set_wel = 1'b1; phase_d = PH_SKIP; end
                OP_CLRWE: begin clr_wel = 1'b1; phase_d = PH_SKIP; end
                OP_RDST:  begin phase_d = PH_STRD; ld_d = 1'b1; end
                OP_WRST:  begin phase_d = PH_STWR; wrf_d = 1'b1; end
                OP_RDMEM: phase_d = PH_AHI;
                OP_WRMEM: begin phase_d = PH_AHI; wrf_d = 1'b1; end
                default:  phase_d = PH_SKIP;
              endcase
            end
            PH_AHI: begin
              addr_d  = {byte_in[HI_W-1:0], addr_q[BYTE_W-1:0]};
              phase_d = PH_ALO;
            end
            PH_ALO: begin
              addr_d = {addr_q[ADDR_W-1:BYTE_W], byte_in};
              if (isrd_q) begin phase_d = PH_RDAT; ld_d = 1'b1; end
              else phase_d = PH_WDAT;
            end
            PH_WDAT: begin
              ram_we = mem_ok;
              addr_d = addr_q + 1'b1;
            end
            PH_RDAT: begin
              addr_d = addr_q + 1'b1;
              ld_d   = 1'b1;
            end
            PH_STRD: ld_d = 1'b1;
            PH_STWR: begin st_we = 1'b1; phase_d = PH_SKIP; end
            default: ;
          endcase
        end
      end
      if (sck_fall && (phase_q == PH_RDAT || phase_q == PH_STRD)) begin
        if (ld_q) begin
          so_d   = src[BYTE_W-1];
          obuf_d = {src[BYTE_W-2:0], 1'b0};
          ld_d   = 1'b0;
          oe_d   = 1'b1;
        end else begin
          so_d   = obuf_q[BYTE_W-1];
          obuf_d = {obuf_q[BYTE_W-2:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q    <= 1'b0;
      phase_q  <= PH_CMD;
      bitcnt_q <= '0;
      shreg_q  <= '0;
      addr_q   <= '0;
      obuf_q   <= '0;
      so_q     <= 1'b0;
      oe_q     <= 1'b0;
      ld_q     <= 1'b0;
      wrf_q    <= 1'b0;
      isrd_q   <= 1'b0;
    end else begin
      sck_q    <= sck_s;
      phase_q  <= phase_d;
      bitcnt_q <= bitcnt_d;
      shreg_q  <= shreg_d;
      addr_q   <= addr_d;
      obuf_q   <= obuf_d;
      so_q     <= so_d;
      oe_q     <= oe_d;
      ld_q     <= ld_d;
      wrf_q    <= wrf_d;
      isrd_q   <= isrd_d;
    end
  end

  assign spi_miso    = so_q;
  assign spi_miso_en = oe_q & ~cs_s & hold_s;

  p_frame_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_s && cs_s) |=> (phase_q == PH_CMD && bitcnt_q == '0 && !spi_miso_en));
  p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    spi_miso_en |-> (phase_q == PH_RDAT || phase_q == PH_STRD));
  p_hold_freeze_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_s |=> ($stable(phase_q) && $stable(bitcnt_q) && $stable(addr_q)));
  p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_WDAT && $past(phase_q) == PH_WDAT && addr_q != $past(addr_q))
      |-> addr_q == ADDR_W'($past(addr_q) + 1'b1));
  p_commit_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |=> (bitcnt_q == '0));
endmodule

// File: tb/sermem_spi_slave_tb.sv
module sermem_spi_slave_tb;
  localparam int HALF = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, hold_n = 1'b1, mosi = 1'b0, wp_n = 1'b1;
  logic miso, miso_en;

  int n_run = 0, n_fail = 0;
  bit m3 = 1'b0, en_any, en_all, hold_en;
  logic [7:0] mdl [256];
  bit m_wel = 1'b0, m_wpen = 1'b0;
  bit [1:0] m_bp = 2'b00;

  always #5 clk = ~clk;

  sermem_spi_slave u_dut (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n),
    .spi_hold_n(hold_n), .spi_mosi(mosi), .wp_n(wp_n),
    .spi_miso(miso), .spi_miso_en(miso_en)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic half();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic fopen();
    sck = m3;
    half();
    cs_n = 1'b0;
    en_any = 1'b0;
    en_all = 1'b1;
    half();
  endtask

  task automatic fclose();
    if (!m3) begin sck = 1'b0; half(); end
    cs_n = 1'b1;
    half(); half();
  endtask

  task automatic do_hold();
    logic b;
    b = mosi;
    hold_n = 1'b0;
    half();
    hold_en = miso_en;
    for (int j = 0; j < 3; j++) begin
      mosi = ~mosi; sck = 1'b1; half();
      hold_en = hold_en | miso_en;
      sck = 1'b0; half();
    end
    mosi = b;
    hold_n = 1'b1;
    half();
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx,
                      input int nb = 8, input int hb = -1);
    rx = 8'h00;
    for (int i = 0; i < nb; i++) begin
      sck = 1'b0;
      mosi = tx[7-i];
      half();
      if (i == hb) do_hold();
      rx[7-i] = miso_en ? miso : 1'b0;
      en_any = en_any | miso_en;
      en_all = en_all & miso_en;
      sck = 1'b1;
      half();
    end
  endtask

  function automatic bit prot(input int a);
    case (m_bp)
      2'd0: return 1'b0;
      2'd1: return (a & 16'h7FFF) >= 16'h6000;
      2'd2: return (a & 16'h7FFF) >= 16'h4000;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [7:0] m_status();
    return {m_wpen, 3'b000, m_bp, m_wel, 1'b0};
  endfunction

  task automatic cmd_only(input logic [7:0] op);
    logic [7:0] rx;
    fopen(); xfer(op, rx); fclose();
  endtask

  task automatic wren(); cmd_only(8'h06); m_wel = 1'b1; endtask
  task automatic wrdi(); cmd_only(8'h04); m_wel = 1'b0; endtask

  task automatic rdsr(output logic [7:0] st);
    logic [7:0] rx;
    fopen(); xfer(8'h05, rx); xfer(8'h00, st); fclose();
  endtask

  task automatic wrsr(input logic [7:0] v);
    logic [7:0] rx;
    fopen(); xfer(8'h01, rx); xfer(v, rx); fclose();
    if (m_wel && !(m_wpen && !wp_n)) begin m_wpen = v[7]; m_bp = v[3:2]; end
    m_wel = 1'b0;
  endtask

  task automatic wr_burst(input int a, input int n, input logic [7:0] base, input int hb = -1);
    logic [7:0] rx, d;
    fopen();
    xfer(8'h02, rx); xfer(8'(a >> 8), rx); xfer(8'(a), rx);
    for (int k = 0; k < n; k++) begin
      d = 8'(base + k * 7);
      xfer(d, rx, 8, (k == 0) ? hb : -1);
      if (m_wel && !prot(a + k)) mdl[(a + k) & 8'hFF] = d;
    end
    fclose();
    m_wel = 1'b0;
  endtask

  task automatic rd_burst(input int a, input int n, input string tag, input int hb = -1);
    logic [7:0] rx;
    fopen();
    xfer(8'h03, rx); xfer(8'(a >> 8), rx); xfer(8'(a), rx);
    chk({tag, " R10 output off during command/address"}, {7'd0, en_any}, 8'h00);
    en_all = 1'b1;
    for (int k = 0; k < n; k++) begin
      xfer(8'hA5, rx, 8, (k == 0) ? hb : -1);
      chk(tag, rx, mdl[(a + k) & 8'hFF]);
    end
    chk({tag, " R10 output on during data"}, {7'd0, en_all}, 8'h01);
    fclose();
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: got hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] st, rx;
    int pa [6];
    pa = '{16'h0011, 16'h3F22, 16'h4033, 16'h5F44, 16'h6055, 16'h7F66};
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10 reset output off", {7'd0, miso_en}, 8'h00);
    rdsr(st); chk("R7 reset status", st, 8'h00);

    // R6 latch set, R5 full burst fill in idle-low clock mode
    wren(); rdsr(st); chk("R6 latch set", st, 8'h02);
    wr_burst(0, 256, 8'h03);
    rdsr(st); chk("R6 latch cleared by write frame", st, 8'h00);
    // R2 read back in idle-high clock mode, R4 increment across 256 bytes
    m3 = 1'b1;
    rd_burst(0, 256, "R2 R4 R5 burst readback");
    m3 = 1'b0;

    // R6 write refused without latch
    wr_burst(16'h0020, 1, 8'h5A);
    rd_burst(16'h0020, 1, "R6 write without latch");
    wren(); wrdi(); rdsr(st); chk("R6 clear latch", st, 8'h00);

    // R4 wrap, R3 ignored top address bit
    wren(); wr_burst(16'h7FFF, 2, 8'hA1);
    rd_burst(16'h7FFF, 2, "R4 wrap 7FFF->0000");
    rd_burst(16'hFFFF, 1, "R3 top bit ignored on read");
    wren(); wr_burst(16'h8040, 1, 8'h77);
    rd_burst(16'h0040, 1, "R3 top bit ignored on write");

    // R7 status fields, R9 status lock
    wren(); wrsr(8'hFF); rdsr(st); chk("R7 status write fields", st, m_status());
    chk("R7 expected encoding", st, 8'h8C);
    wp_n = 1'b0;
    wren(); wrsr(8'h00); rdsr(st); chk("R9 status locked", st, 8'h8C);
    wp_n = 1'b1;
    wren(); wrsr(8'h00); rdsr(st); chk("R9 status unlocked", st, 8'h00);

    // R8 block-protect sweep
    for (int bp = 0; bp < 4; bp++) begin
      wren(); wrsr(8'(bp << 2));
      for (int i = 0; i < 6; i++) begin
        wren(); wr_burst(pa[i], 1, 8'(bp * 16 + i + 8'h80));
      end
      for (int i = 0; i < 6; i++) rd_burst(pa[i], 1, $sformatf("R8 bp=%0d addr=%h", bp, pa[i]));
    end
    wren(); wrsr(8'h00);

    // R12 unknown opcodes
    wren();
    fopen(); xfer(8'h12, rx); xfer(8'h00, rx); xfer(8'h50, rx); xfer(8'h99, rx);
    chk("R12 no output after unknown op", {7'd0, en_any}, 8'h00); fclose();
    fopen(); xfer(8'h07, rx); xfer(8'h00, rx); xfer(8'h50, rx); xfer(8'h99, rx); fclose();
    rd_burst(16'h0050, 1, "R12 memory untouched");
    rdsr(st); chk("R12 latch kept", st, 8'h02);

    // R1 one command per frame
    fopen(); xfer(8'h04, rx); xfer(8'h06, rx); fclose(); m_wel = 1'b0;
    rdsr(st); chk("R1 second byte ignored", st, 8'h00);

    // R5 partial byte discarded
    wren();
    fopen(); xfer(8'h02, rx); xfer(8'h00, rx); xfer(8'h60, rx); xfer(8'hC3, rx, 5); fclose();
    m_wel = 1'b0;
    rd_burst(16'h0060, 1, "R5 partial byte");

    // R11 hold mid-byte in write and read
    wren(); wr_burst(16'h0070, 2, 8'h3C, 3);
    chk("R11 output off during write hold", {7'd0, hold_en}, 8'h00);
    m3 = 1'b1;
    rd_burst(16'h0070, 2, "R11 resume after hold", 5);
    chk("R11 output off during read hold", {7'd0, hold_en}, 8'h00);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule